// File: doc/BRIEF.md
# Boot-Default Chip-Select Decoder

This block sits between a processor-style request port and a set of external memory and peripheral devices. Each accepted request is turned into a complete external bus cycle. The cycle drives a device chip-select, the address, and either a read strobe (output enable) or a write strobe, with a programmable number of wait states. Software sets up four match windows. Each window compares the request address under a mask against a base, and also compares the request's memory-or-IO type. Window 0 wins when windows overlap.

Out of reset, the windows are not used. Every memory access, at any address, goes to a single boot chip-select. That cycle uses slow default timing, suited to a plain ROM. The ROM is given only the low word-address bits: bits 15 down to 2 of the request address, so each access is one 32-bit word. In this boot mode, IO accesses are refused with an error. Firmware leaves boot mode by setting a bit in the control register. From then on, only enabled windows decode, and an access that hits no window completes with an error and selects no device.

Top module: `bootcs_decoder`

## Requirements
- R1: After reset, all chip-selects, both strobes, `req_ready` and `rsp_err` are low. The block starts in boot mode with every window disabled.
- R2: In boot mode, any memory access (`req_is_io`=0) asserts `ext_boot_cs` and no window chip-select. This holds at every address and whatever the windows are programmed to.
- R3: In boot mode, an IO access asserts no chip-select. It completes in the first cycle after acceptance with `req_ready`=1 and `rsp_err`=1.
- R4: A boot cycle holds its strobe for boot-wait+1 cycles. The boot-wait field resets to 15.
- R5: During a boot cycle, `ext_rom_addr` equals request address bits [15:2].
- R6: A read asserts only `ext_oe` and a write asserts only `ext_we`. So `ext_we` never rises during a boot read.
- R7: Chip-select rises one cycle before the strobe and stays high for one cycle after it. `req_ready` is high only in the last strobe cycle, or in an error completion.
- R8: In window mode, window i hits when three things hold: it is enabled, its type bit equals `req_is_io`, and ((addr XOR base) AND mask) is zero. `ext_addr` then carries the full request address.
- R9: When several windows hit, only the lowest-numbered one is selected. At most one chip-select is ever high.
- R10: A window cycle holds its strobe for that window's wait+1 cycles (wait 0 to 15).
- R11: In window mode, an access that hits no window completes in the first cycle after acceptance with `rsp_err`=1 and no chip-select.
- R12: The configuration write map, with NWIN=4, is as follows. `cfg_sel` 0..3 sets the base of window 0..3, and 4..7 sets its mask. 8..11 sets its attributes: bit0 enable, bit1 type (1=IO), bits[7:4] wait. 12 is the control register: bit0 leaves boot mode (0 returns to it), bits[7:4] boot wait.
- R13: On a read, `rsp_rdata` equals `ext_rdata` in the cycle where `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present; held until `req_ready` |
| req_ready | output | 1 | Request completes this cycle |
| req_addr | input | ADDR_W | Request byte address |
| req_is_io | input | 1 | 1 = IO access, 0 = memory access |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | DATA_W | Write data |
| rsp_rdata | output | DATA_W | Read data, valid with `req_ready` |
| rsp_err | output | 1 | Access refused, valid with `req_ready` |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | SEL_W | Configuration register select |
| cfg_wdata | input | ADDR_W | Configuration write data |
| ext_cs | output | NWIN | Window chip-selects, active high |
| ext_boot_cs | output | 1 | Boot device chip-select, active high |
| ext_addr | output | ADDR_W | Full address for window devices |
| ext_rom_addr | output | ROM_AW-2 | Word address for the boot device |
| ext_oe | output | 1 | Read strobe (output enable) |
| ext_we | output | 1 | Write strobe |
| ext_wdata | output | DATA_W | Write data to the device |
| ext_rdata | input | DATA_W | Read data from the device |

## Verification
The bench targets three kinds of corner case. The first is the reset default: memory accesses at extreme addresses such as 0xFFFF0000 and 0x00000000, and addresses that lie inside already-programmed windows, must still reach the boot device. A decoder that lets windows decode before the control bit is set would select a window chip-select there instead. The second is windows that overlap, together with type mismatches. Here a broken priority chain shows up as a wrong or doubled select, and a missing type compare lets IO reach a memory window. The third is strobe lengths at wait 0, 2, 3, 5 and 15. These expose off-by-one errors in the wait counter, a ready pulse outside the last strobe cycle, and a chip-select that drops together with the strobe rather than one cycle later.

// File: rtl/bcd_pkg.sv
package bcd_pkg;
    localparam int ADDR_W = 32;
    localparam int DATA_W = 32;
    localparam int WAIT_W = 4;
    localparam int ROM_AW = 16;

    typedef struct packed {
        logic [ADDR_W-1:0] base;
        logic [ADDR_W-1:0] mask;
        logic              en;
        logic              io;
        logic [WAIT_W-1:0] wait_n;
    } win_cfg_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_STROBE,
        ST_HOLD,
        ST_ERR
    } cyc_state_t;
endpackage

// File: rtl/bcd_cfg_regs.sv
module bcd_cfg_regs
    import bcd_pkg::*;
#(
    parameter int NWIN  = 4,
    parameter int SEL_W = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cfg_we,
    input  logic [SEL_W-1:0]         cfg_sel,
    input  logic [ADDR_W-1:0]        cfg_wdata,
    output win_cfg_t [NWIN-1:0]      win_o,
    output logic                     win_on_o,
    output logic [WAIT_W-1:0]        boot_wait_o
);
    typedef struct packed {
        win_cfg_t [NWIN-1:0] win;
        logic                win_on;
        logic [WAIT_W-1:0]   boot_wait;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (cfg_we) begin
            for (int i = 0; i < NWIN; i++) begin
                if (cfg_sel == SEL_W'(i))
                    r_d.win[i].base = cfg_wdata;
                if (cfg_sel == SEL_W'(NWIN + i))
                    r_d.win[i].mask = cfg_wdata;
                if (cfg_sel == SEL_W'(2 * NWIN + i)) begin
                    r_d.win[i].en     = cfg_wdata[0];
                    r_d.win[i].io     = cfg_wdata[1];
                    r_d.win[i].wait_n = cfg_wdata[4 +: WAIT_W];
                end
            end
            if (cfg_sel == SEL_W'(3 * NWIN)) begin
                r_d.win_on    = cfg_wdata[0];
                r_d.boot_wait = cfg_wdata[4 +: WAIT_W];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q           <= '0;
            r_q.boot_wait <= '1;
        end else begin
            r_q <= r_d;
        end
    end

    assign win_o       = r_q.win;
    assign win_on_o    = r_q.win_on;
    assign boot_wait_o = r_q.boot_wait;
endmodule

// File: rtl/bcd_win_match.sv
module bcd_win_match
    import bcd_pkg::*;
#(
    parameter int NWIN = 4
) (
    input  win_cfg_t [NWIN-1:0] win_i,
    input  logic                win_on_i,
    input  logic [WAIT_W-1:0]   boot_wait_i,
    input  logic [ADDR_W-1:0]   addr_i,
    input  logic                is_io_i,
    output logic [NWIN-1:0]     grant_o,
    output logic                boot_o,
    output logic                miss_o,
    output logic [WAIT_W-1:0]   wait_o
);
    logic [NWIN-1:0] raw_hit;

    for (genvar g = 0; g < NWIN; g++) begin : g_cmp
        assign raw_hit[g] = win_i[g].en && (win_i[g].io == is_io_i) &&
                            (((addr_i ^ win_i[g].base) & win_i[g].mask) == '0);
    end

    logic [NWIN-1:0]   pick;
    logic              found;
    logic [WAIT_W-1:0] pick_wait;

    always_comb begin
        pick      = '0;
        found     = 1'b0;
        pick_wait = '0;
        for (int i = 0; i < NWIN; i++) begin
            if (!found && raw_hit[i]) begin
                pick[i]   = 1'b1;
                found     = 1'b1;
                pick_wait = win_i[i].wait_n;
            end
        end
    end

    always_comb begin
        if (win_on_i) begin
            grant_o = pick;
            boot_o  = 1'b0;
            miss_o  = !found;
            wait_o  = pick_wait;
        end else begin
            grant_o = '0;
            boot_o  = !is_io_i;
            miss_o  = is_io_i;
            wait_o  = boot_wait_i;
        end
    end
endmodule

// File: rtl/bcd_cycle_fsm.sv
module bcd_cycle_fsm
    import bcd_pkg::*;
#(
    parameter int NWIN = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic                req_write,
    input  logic [DATA_W-1:0]   req_wdata,
    input  logic [NWIN-1:0]     grant_i,
    input  logic                boot_i,
    input  logic                miss_i,
    input  logic [WAIT_W-1:0]   wait_i,
    input  logic [DATA_W-1:0]   ext_rdata,
    output logic                req_ready,
    output logic                rsp_err,
    output logic [DATA_W-1:0]   rsp_rdata,
    output logic [NWIN-1:0]     ext_cs,
    output logic                ext_boot_cs,
    output logic [ADDR_W-1:0]   ext_addr,
    output logic [ROM_AW-3:0]   ext_rom_addr,
    output logic                ext_oe,
    output logic                ext_we,
    output logic [DATA_W-1:0]   ext_wdata
);
    typedef struct packed {
        cyc_state_t        st;
        logic [WAIT_W-1:0] cnt;
        logic [NWIN-1:0]   cs;
        logic              boot;
        logic [ADDR_W-1:0] addr;
        logic              wr;
        logic [DATA_W-1:0] wdata;
    } fsm_t;

    fsm_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        unique case (s_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    if (miss_i) begin
                        s_d.st = ST_ERR;
                    end else begin
                        s_d.st    = ST_SETUP;
                        s_d.cs    = grant_i;
                        s_d.boot  = boot_i;
                        s_d.cnt   = wait_i;
                        s_d.addr  = req_addr;
                        s_d.wr    = req_write;
                        s_d.wdata = req_wdata;
                    end
                end
            end
            ST_SETUP:  s_d.st = ST_STROBE;
            ST_STROBE: begin
                if (s_q.cnt == '0) s_d.st = ST_HOLD;
                else               s_d.cnt = s_q.cnt - 1'b1;
            end
            ST_HOLD: begin
                s_d.st   = ST_IDLE;
                s_d.cs   = '0;
                s_d.boot = 1'b0;
            end
            ST_ERR:  s_d.st = ST_IDLE;
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    logic in_strobe, last_strobe;
    assign in_strobe   = (s_q.st == ST_STROBE);
    assign last_strobe = in_strobe && (s_q.cnt == '0);

    assign req_ready    = last_strobe || (s_q.st == ST_ERR);
    assign rsp_err      = (s_q.st == ST_ERR);
    assign rsp_rdata    = (last_strobe && !s_q.wr) ? ext_rdata : '0;
    assign ext_cs       = s_q.cs;
    assign ext_boot_cs  = s_q.boot;
    assign ext_addr     = s_q.addr;
    assign ext_rom_addr = s_q.addr[ROM_AW-1:2];
    assign ext_oe       = in_strobe && !s_q.wr;
    assign ext_we       = in_strobe && s_q.wr;
    assign ext_wdata    = s_q.wdata;
endmodule

// File: rtl/bootcs_decoder.sv
module bootcs_decoder
    import bcd_pkg::*;
#(
    parameter int  NWIN  = 4,
    localparam int SEL_W = $clog2(3 * NWIN + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic                req_is_io,
    input  logic                req_write,
    input  logic [DATA_W-1:0]   req_wdata,
    output logic [DATA_W-1:0]   rsp_rdata,
    output logic                rsp_err,
    input  logic                cfg_we,
    input  logic [SEL_W-1:0]    cfg_sel,
    input  logic [ADDR_W-1:0]   cfg_wdata,
    output logic [NWIN-1:0]     ext_cs,
    output logic                ext_boot_cs,
    output logic [ADDR_W-1:0]   ext_addr,
    output logic [ROM_AW-3:0]   ext_rom_addr,
    output logic                ext_oe,
    output logic                ext_we,
    output logic [DATA_W-1:0]   ext_wdata,
    input  logic [DATA_W-1:0]   ext_rdata
);
    win_cfg_t [NWIN-1:0] win;
    logic                win_on;
    logic [WAIT_W-1:0]   boot_wait;
    logic [NWIN-1:0]     grant;
    logic                boot_sel;
    logic                miss;
    logic [WAIT_W-1:0]   wait_sel;

    bcd_cfg_regs #(.NWIN(NWIN), .SEL_W(SEL_W)) regs_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_we      (cfg_we),
        .cfg_sel     (cfg_sel),
        .cfg_wdata   (cfg_wdata),
        .win_o       (win),
        .win_on_o    (win_on),
        .boot_wait_o (boot_wait)
    );

    bcd_win_match #(.NWIN(NWIN)) match_i (
        .win_i       (win),
        .win_on_i    (win_on),
        .boot_wait_i (boot_wait),
        .addr_i      (req_addr),
        .is_io_i     (req_is_io),
        .grant_o     (grant),
        .boot_o      (boot_sel),
        .miss_o      (miss),
        .wait_o      (wait_sel)
    );

    bcd_cycle_fsm #(.NWIN(NWIN)) fsm_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .req_addr     (req_addr),
        .req_write    (req_write),
        .req_wdata    (req_wdata),
        .grant_i      (grant),
        .boot_i       (boot_sel),
        .miss_i       (miss),
        .wait_i       (wait_sel),
        .ext_rdata    (ext_rdata),
        .req_ready    (req_ready),
        .rsp_err      (rsp_err),
        .rsp_rdata    (rsp_rdata),
        .ext_cs       (ext_cs),
        .ext_boot_cs  (ext_boot_cs),
        .ext_addr     (ext_addr),
        .ext_rom_addr (ext_rom_addr),
        .ext_oe       (ext_oe),
        .ext_we       (ext_we),
        .ext_wdata    (ext_wdata)
    );
endmodule

// File: rtl/bcd_checker.sv
module bcd_checker #(
    parameter int NWIN = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_ready,
    input logic            rsp_err,
    input logic [NWIN-1:0] ext_cs,
    input logic            ext_boot_cs,
    input logic            ext_oe,
    input logic            ext_we
);
    logic cs_any, strobe;
    assign cs_any = (|ext_cs) || ext_boot_cs;
    assign strobe = ext_oe || ext_we;

    AST_ONE_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ext_cs, ext_boot_cs})); // R9
    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(ext_oe && ext_we)); // R6
    AST_STROBE_NEEDS_CS: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |-> cs_any); // R7
    AST_CS_LEADS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(strobe) |-> $past(cs_any)); // R7
    AST_CS_TRAILS: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(strobe) |-> cs_any); // R7
    AST_ERR_NO_CS: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready && rsp_err) |-> !cs_any); // R11
    AST_READY_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (rsp_err || strobe)); // R7
endmodule

bind bootcs_decoder bcd_checker #(.NWIN(NWIN)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_ready   (req_ready),
    .rsp_err     (rsp_err),
    .ext_cs      (ext_cs),
    .ext_boot_cs (ext_boot_cs),
    .ext_oe      (ext_oe),
    .ext_we      (ext_we)
);

// File: tb/bootcs_decoder_tb_top.sv
module bootcs_decoder_tb_top;
    localparam int NWIN = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_addr = '0;
    logic        req_is_io = 1'b0;
    logic        req_write = 1'b0;
    logic [31:0] req_wdata = '0;
    logic [31:0] rsp_rdata;
    logic        rsp_err;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_sel = '0;
    logic [31:0] cfg_wdata = '0;
    logic [3:0]  ext_cs;
    logic        ext_boot_cs;
    logic [31:0] ext_addr;
    logic [13:0] ext_rom_addr;
    logic        ext_oe;
    logic        ext_we;
    logic [31:0] ext_wdata;
    logic [31:0] ext_rdata;

    assign ext_rdata = {~req_addr[15:0], req_addr[31:16]};

    always #5 clk = ~clk;

    bootcs_decoder #(.NWIN(NWIN)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_is_io(req_is_io), .req_write(req_write),
        .req_wdata(req_wdata), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .ext_cs(ext_cs), .ext_boot_cs(ext_boot_cs), .ext_addr(ext_addr),
        .ext_rom_addr(ext_rom_addr), .ext_oe(ext_oe), .ext_we(ext_we),
        .ext_wdata(ext_wdata), .ext_rdata(ext_rdata)
    );

    int checks = 0;
    int errs   = 0;

    bit          m_win_on = 1'b0;
    int          m_boot_wait = 15;
    logic [31:0] m_base [NWIN];
    logic [31:0] m_mask [NWIN];
    bit          m_en   [NWIN];
    bit          m_io   [NWIN];
    int          m_wait [NWIN];

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cfg_write(input int sel, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = 4'(sel); cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // R12: base at sel i, mask at 4+i, attributes at 8+i
    task automatic set_win(input int i, input logic [31:0] b, input logic [31:0] m,
                           input bit en, input bit io, input int w);
        cfg_write(i, b);
        cfg_write(NWIN + i, m);
        cfg_write(2 * NWIN + i, {24'h0, 4'(w), 2'b00, io, en});
        m_base[i] = b; m_mask[i] = m; m_en[i] = en; m_io[i] = io; m_wait[i] = w;
    endtask

    // R12: control at sel 12, bit0 leaves boot mode, bits[7:4] boot wait
    task automatic set_ctrl(input bit on, input int bw);
        cfg_write(3 * NWIN, {24'h0, 4'(bw), 3'b000, on});
        m_win_on = on; m_boot_wait = bw;
    endtask

    // -2 boot device, -1 refused, otherwise window index
    function automatic int exp_target(input logic [31:0] a, input bit io);
        if (!m_win_on) return io ? -1 : -2;
        for (int i = 0; i < NWIN; i++)
            if (m_en[i] && m_io[i] == io && ((a ^ m_base[i]) & m_mask[i]) == 32'h0) return i;
        return -1;
    endfunction

    task automatic access(input logic [31:0] a, input bit io, input bit wr);
        int          tgt;
        int          w;
        int          nstb;
        bit          rdy_ok;
        bit          rd_ok;
        bit          saw_we;
        logic [3:0]  ecs;
        bit          eboot;
        logic [31:0] erd;
        tgt = exp_target(a, io);
        erd = {~a[15:0], a[31:16]};
        @(negedge clk);
        req_addr = a; req_is_io = io; req_write = wr; req_wdata = ~a; req_valid = 1'b1;
        @(negedge clk);
        if (tgt == -1) begin
            chk(req_ready && rsp_err && ext_cs == 4'h0 && !ext_boot_cs && !ext_oe && !ext_we,
                m_win_on ? "R11 refused access" : "R3 boot-mode IO refused",
                {27'h0, req_ready, rsp_err, ext_boot_cs, ext_oe, ext_we}, 32'h18);
            req_valid = 1'b0;
            return;
        end
        eboot = (tgt == -2);
        ecs   = eboot ? 4'h0 : 4'(1 << tgt);
        w     = eboot ? m_boot_wait : m_wait[tgt];
        chk(ext_boot_cs == eboot && ext_cs == ecs && !ext_oe && !ext_we && !req_ready,
            eboot ? "R2 boot select setup" : "R9 window select setup",
            {27'h0, ext_boot_cs, ext_cs}, {27'h0, eboot, ecs});
        if (eboot) chk(ext_rom_addr == a[15:2], "R5 boot word address", 32'(ext_rom_addr), 32'(a[15:2]));
        else       chk(ext_addr == a, "R8 window address", ext_addr, a);
        nstb = 0; rdy_ok = 1'b1; rd_ok = 1'b1; saw_we = 1'b0;
        for (int k = 0; k <= w; k++) begin
            @(negedge clk);
            if (ext_oe == !wr && ext_we == wr && ext_cs == ecs && ext_boot_cs == eboot) nstb++;
            if (ext_we) saw_we = 1'b1;
            if (req_ready != (k == w) || rsp_err) rdy_ok = 1'b0;
            if (k == w && !wr && rsp_rdata != erd) rd_ok = 1'b0;
        end
        chk(nstb == w + 1, eboot ? "R4 boot strobe length" : "R10 window strobe length",
            32'(nstb), 32'(w + 1));
        chk(rdy_ok, "R7 ready in last strobe cycle", 32'(rdy_ok), 32'h1);
        if (!wr) chk(rd_ok, "R13 read data", rsp_rdata, erd);
        if (eboot && !wr) chk(!saw_we, "R6 no write strobe on boot read", 32'(saw_we), 32'h0);
        req_valid = 1'b0;
        @(negedge clk);
        chk(ext_cs == ecs && ext_boot_cs == eboot && !ext_oe && !ext_we && !req_ready,
            "R7 chip-select hold cycle", {27'h0, ext_boot_cs, ext_cs}, {27'h0, eboot, ecs});
        @(negedge clk);
        chk(ext_cs == 4'h0 && !ext_boot_cs, "R7 chip-select released",
            {27'h0, ext_boot_cs, ext_cs}, 32'h0);
    endtask

    function automatic logic [7:0] top_byte(input int k);
        case (k)
            0: return 8'h12; 1: return 8'h13; 2: return 8'h80; 3: return 8'hFF;
            4: return 8'h00; 5: return 8'h7F; 6: return 8'hC0; default: return 8'h92;
        endcase
    endfunction

    function automatic logic [7:0] mid_byte(input int j);
        case (j)
            0: return 8'h34; 1: return 8'h00; 2: return 8'h35; default: return 8'hFF;
        endcase
    endfunction

    task automatic sweep();
        for (int k = 0; k < 8; k++)
            for (int j = 0; j < 4; j++)
                for (int io = 0; io < 2; io++)
                    access({top_byte(k), mid_byte(j), 16'h0304 ^ 16'(k * 4)}, io[0], 1'((k + j) % 2));
    endtask

    initial begin
        for (int i = 0; i < NWIN; i++) begin
            m_base[i] = '0; m_mask[i] = '0; m_en[i] = 1'b0; m_io[i] = 1'b0; m_wait[i] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(ext_cs == 4'h0 && !ext_boot_cs && !ext_oe && !ext_we && !req_ready && !rsp_err,
            "R1 reset outputs", {26'h0, ext_cs, ext_boot_cs, ext_oe}, 32'h0);

        // R2 R4 R5: boot mode at spread addresses, reset boot wait 15
        access(32'hFFFF_0000, 1'b0, 1'b0);
        access(32'h0000_0000, 1'b0, 1'b0);
        access(32'hFFFF_FFFC, 1'b0, 1'b0);
        for (int i = 0; i < 12; i++)
            access(32'(i) * 32'h1357_9BDF + 32'h0003_FF00, 1'b0, 1'(i % 3 == 0));
        // R3: IO refused in boot mode
        access(32'h0000_0300, 1'b1, 1'b0);
        access(32'h0000_0304, 1'b1, 1'b1);

        // R12: shorten boot wait, stay in boot mode
        set_ctrl(1'b0, 2);
        access(32'h0001_2344, 1'b0, 1'b0);

        // windows programmed but not in use yet
        set_win(0, 32'h1234_0000, 32'hFFFF_0000, 1'b1, 1'b0, 1);
        set_win(1, 32'h1200_0000, 32'hFF00_0000, 1'b1, 1'b0, 3);
        set_win(2, 32'h0000_0300, 32'h0000_FF00, 1'b1, 1'b1, 0);
        set_win(3, 32'h8000_0000, 32'h8000_0000, 1'b0, 1'b0, 5);
        access(32'h1234_0010, 1'b0, 1'b0);  // R2 still boot
        access(32'h0000_0300, 1'b1, 1'b0);  // R3 still refused

        // R8 R9 R10 R11: window mode sweeps
        set_ctrl(1'b1, 2);
        sweep();
        set_win(3, 32'h8000_0000, 32'h8000_0000, 1'b1, 1'b0, 5);
        sweep();
        set_win(1, 32'h0000_0000, 32'h0000_0000, 1'b1, 1'b1, 15);  // IO catch-all below win2
        sweep();

        // back to boot mode
        set_ctrl(1'b0, 0);
        access(32'h8000_0008, 1'b0, 1'b0);
        access(32'h1234_0000, 1'b0, 1'b1);

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errs++;
        checks++;
        $display("FAIL watchdog expired actual=%0d expected=0", 150000);
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule